// File: doc/BRIEF.md
# Dual-Slope Centre-Aligned PWM Timer

This block is an up/down counter that produces centre-aligned pulse-width modulation on two outputs. The counter advances only when an external prescaler enable is high. It climbs from zero to a selectable ceiling, spends exactly one step there, and then falls back towards zero. One full up/down cycle lasts twice the ceiling value in steps. Each of the two channels compares the count with its own threshold. A channel changes its output level only on a match, and whether the match clears or sets the output depends on the counting direction. Because of this the pulses stay centred on the bottom of the count, or on the ceiling when a channel is inverted.

The ceiling comes from one of five sources: three fixed all-ones limits of 8, 9 and 10 bits, the live channel-A threshold, or a separate period register. The channel-A threshold is written into a holding buffer. It is copied into the live value either at the ceiling turn or when the count returns to zero, and a configuration input picks which. Copying at zero keeps every up/down cycle symmetric when the threshold changes. The period register takes effect at once with no buffering. Three one-clock event pulses mark returns to zero and threshold matches, so neighbouring logic can use them as interrupt sources.

Top module: `dsp_pwm_timer`

## Requirements
- R1: On each step with a ceiling T > 0 the count runs 0, 1, ..., T, T-1, ..., 1 and repeats, so the cycle lasts 2·T steps. In any clock where `tick` is low the count and every output hold their values.
- R2: `top_sel` chooses the ceiling: 0 → 255, 1 → 511, 2 → 1023, 3 → live channel-A threshold, 4 → period register. Codes 5 to 7 behave like 0.
- R3: `count_down` is 0 after reset. It goes to 1 on the step taken while the count equals the ceiling, and back to 0 on the step that brings the count to 0.
- R4: `ovf_evt` is high for one clock, in the clock where a step has just brought the count to 0. `cmpa_evt` and `cmpb_evt` are high in each clock where a step has just made the count equal to that channel's threshold.
- R5: In non-inverting mode (`inv_x` = 0), a step taken while the count equals the threshold drives the output low when counting up and high when counting down. The new level appears one clock after the count shows the match. For 0 < C < T the output is high for 2·C steps of each cycle.
- R6: With `inv_x` = 1 the output is the complement of the non-inverting level, so it is high for 2·(T−C) steps per cycle.
- R7: A threshold of 0 keeps the output at its inactive level (low when non-inverting) for the whole cycle, with no one-step pulse. A threshold equal to the ceiling keeps it at its active level for the whole cycle.
- R8: With `load_at_bottom` = 0, a value written through `cmp_a_wr` becomes live on the step taken at the ceiling. A write during the rising half therefore applies to the falling half of the same cycle.
- R9: With `load_at_bottom` = 1, a written channel-A value becomes live only on the step that brings the count to 0, so both halves of every cycle use the same threshold.
- R10: A period-register write applies on the next clock edge. If the value is below a rising count, the counter keeps rising up to 65535, wraps to 0 with an `ovf_evt`, and then runs normal cycles against the new ceiling.
- R11: With a ceiling of 0 the count stays at 0, `count_down` stays 0, both outputs hold their inactive level, and `ovf_evt` is high after every step.
- R12: A synchronous reset clears the count, direction, event pulses, the channel-A buffer and live value, and the period register. During reset each output shows its inactive level (`pwm_x` = `inv_x`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaler step enable |
| top_sel | input | 3 | Ceiling source select |
| load_at_bottom | input | 1 | 1: channel-A value goes live at zero; 0: at the ceiling |
| inv_a | input | 1 | Channel A inverting mode |
| inv_b | input | 1 | Channel B inverting mode |
| cmp_a_wr | input | 1 | Write strobe for the channel-A holding buffer |
| cmp_a_wdata | input | 16 | Channel-A threshold write data |
| period_wr | input | 1 | Write strobe for the period register |
| period_wdata | input | 16 | Period register write data |
| cmp_b | input | 16 | Channel-B threshold |
| count | output | 16 | Current count |
| count_down | output | 1 | Direction, 1 while falling |
| pwm_a | output | 1 | Channel A waveform |
| pwm_b | output | 1 | Channel B waveform |
| ovf_evt | output | 1 | Count reached zero |
| cmpa_evt | output | 1 | Count reached channel-A threshold |
| cmpb_evt | output | 1 | Count reached channel-B threshold |

## Verification
The assertions assume that the ceiling source and the thresholds change only between runs or through the documented write strobes. They also assume that `cmp_b` is stable while a cycle is being measured, so the one-step-per-tick relations and the direction checks follow from a steady ceiling. The stimulus respects this by applying a reset before each configuration. Thresholds are written with `tick` held low, and only the channel-A buffer and the period register are changed during a run, through their strobes, in the tests that exercise them.

// File: rtl/dsp_pwm_pkg.sv
package dsp_pwm_pkg;

  // Ceiling source codes carried on top_sel
  typedef enum logic [2:0] {
    TSEL_FULL8  = 3'd0,
    TSEL_FULL9  = 3'd1,
    TSEL_FULL10 = 3'd2,
    TSEL_CMPA   = 3'd3,
    TSEL_PERIOD = 3'd4
  } top_src_e;

  // Events from the counter that decide when the channel-A value goes live
  typedef struct packed {
    logic up_at_top;   // step taken while rising and sitting on the ceiling
    logic reach_zero;  // step that lands the count on zero
  } load_ev_t;

endpackage

// File: rtl/dsp_top_cfg.sv
module dsp_top_cfg
  import dsp_pwm_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned FULL_BITS_0 = 8,
  parameter int unsigned FULL_BITS_1 = 9,
  parameter int unsigned FULL_BITS_2 = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       top_sel_i,
  input  logic             load_at_bottom_i,
  input  logic             cmp_a_wr_i,
  input  logic [CNT_W-1:0] cmp_a_wdata_i,
  input  logic             period_wr_i,
  input  logic [CNT_W-1:0] period_wdata_i,
  input  load_ev_t         ev_i,
  output logic [CNT_W-1:0] top_o,
  output logic [CNT_W-1:0] cmp_a_o
);

  localparam logic [CNT_W-1:0] FULL0 = CNT_W'((64'd1 << FULL_BITS_0) - 64'd1);
  localparam logic [CNT_W-1:0] FULL1 = CNT_W'((64'd1 << FULL_BITS_1) - 64'd1);
  localparam logic [CNT_W-1:0] FULL2 = CNT_W'((64'd1 << FULL_BITS_2) - 64'd1);

  logic [CNT_W-1:0] cmp_a_buf;
  logic [CNT_W-1:0] period_q;
  logic             load_now;

  // Load point picks between the two counter events
  assign load_now = load_at_bottom_i ? ev_i.reach_zero : ev_i.up_at_top;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_a_buf <= '0;
      cmp_a_o   <= '0;
      period_q  <= '0;
    end else begin
      if (cmp_a_wr_i)  cmp_a_buf <= cmp_a_wdata_i;
      if (load_now)    cmp_a_o   <= cmp_a_buf;
      if (period_wr_i) period_q  <= period_wdata_i;
    end
  end

  always_comb begin
    case (top_src_e'(top_sel_i))
      TSEL_FULL8:  top_o = FULL0;
      TSEL_FULL9:  top_o = FULL1;
      TSEL_FULL10: top_o = FULL2;
      TSEL_CMPA:   top_o = cmp_a_o;
      TSEL_PERIOD: top_o = period_q;
      default:     top_o = FULL0;
    endcase
  end

  // R8
  load_top_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_at_bottom_i && !ev_i.up_at_top) |=> (cmp_a_o == $past(cmp_a_o)));

  // R9
  load_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (load_at_bottom_i && !ev_i.reach_zero) |=> (cmp_a_o == $past(cmp_a_o)));

endmodule

// File: rtl/dsp_updown_cnt.sv
module dsp_updown_cnt
  import dsp_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] top_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] nxt_o,
  output logic             down_o,
  output load_ev_t         ev_o,
  output logic             ovf_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] ZERO    = '0;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic down_nxt;

  always_comb begin
    nxt_o    = cnt_o;
    down_nxt = down_o;
    if (tick) begin
      if (top_i == ZERO) begin
        nxt_o    = ZERO;
        down_nxt = 1'b0;
      end else if (!down_o) begin
        if (cnt_o == top_i) begin
          // one step at the ceiling, then fall; a ceiling of 1 stays rising
          nxt_o    = cnt_o - ONE;
          down_nxt = (cnt_o != ONE);
        end else if (cnt_o == CNT_MAX) begin
          nxt_o = ZERO;  // ran past a lowered ceiling
        end else begin
          nxt_o = cnt_o + ONE;
        end
      end else begin
        if (cnt_o <= ONE) begin
          nxt_o    = ZERO;
          down_nxt = 1'b0;
        end else begin
          nxt_o = cnt_o - ONE;
        end
      end
    end
  end

  assign ev_o.up_at_top  = tick && !down_o && (cnt_o == top_i);
  assign ev_o.reach_zero = tick && (nxt_o == ZERO);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o  <= ZERO;
      down_o <= 1'b0;
      ovf_o  <= 1'b0;
    end else begin
      cnt_o  <= nxt_o;
      down_o <= down_nxt;
      ovf_o  <= ev_o.reach_zero;
    end
  end

  // R1
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> (cnt_o == $past(cnt_o)));

  // R1
  step_up_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !down_o && (cnt_o < top_i)) |=> (cnt_o == CNT_W'($past(cnt_o) + ONE)));

  // R3
  turn_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !down_o && (cnt_o == top_i) && (top_i > ONE)) |=> down_o);

  // R3
  down_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    down_o |-> (cnt_o != ZERO));

  // R4
  ovf_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> (cnt_o == ZERO));

  // R10
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !down_o && (cnt_o == CNT_MAX) && (top_i != CNT_MAX)) |=> (cnt_o == ZERO && ovf_o));

  // R11
  zero_top_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && (top_i == ZERO)) |=> (cnt_o == ZERO && !down_o && ovf_o));

endmodule

// File: rtl/dsp_cmp_chan.sv
module dsp_cmp_chan #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] nxt_i,
  input  logic             down_i,
  input  logic [CNT_W-1:0] top_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             inv_i,
  output logic             pwm_o,
  output logic             evt_o
);

  logic active_q;
  logic active_nxt;

  // Active level: cleared by a rising match, set by a falling match,
  // forced on when the match sits on the ceiling, forced off at ceiling 0
  always_comb begin
    active_nxt = active_q;
    if (tick) begin
      if (top_i == '0) begin
        active_nxt = 1'b0;
      end else if (cnt_i == cmp_i) begin
        active_nxt = (cnt_i == top_i) ? 1'b1 : down_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      pwm_o    <= inv_i;
      evt_o    <= 1'b0;
    end else begin
      active_q <= active_nxt;
      pwm_o    <= active_nxt ^ inv_i;
      evt_o    <= tick && (nxt_i == cmp_i);
    end
  end

  // R4
  evt_match_chk: assert property (@(posedge clk) disable iff (rst)
    evt_o |-> (cnt_i == $past(cmp_i)));

  // R1
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && $stable(inv_i)) |=> $stable(pwm_o));

  // R11
  out_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && (top_i == '0)) |=> (pwm_o == $past(inv_i)));

endmodule

// File: rtl/dsp_pwm_timer.sv
module dsp_pwm_timer
  import dsp_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [2:0]       top_sel,
  input  logic             load_at_bottom,
  input  logic             inv_a,
  input  logic             inv_b,
  input  logic             cmp_a_wr,
  input  logic [CNT_W-1:0] cmp_a_wdata,
  input  logic             period_wr,
  input  logic [CNT_W-1:0] period_wdata,
  input  logic [CNT_W-1:0] cmp_b,
  output logic [CNT_W-1:0] count,
  output logic             count_down,
  output logic             pwm_a,
  output logic             pwm_b,
  output logic             ovf_evt,
  output logic             cmpa_evt,
  output logic             cmpb_evt
);

  localparam int unsigned NUM_CH = 2;

  logic [CNT_W-1:0] top_w;
  logic [CNT_W-1:0] cmp_a_live;
  logic [CNT_W-1:0] cnt_nxt;
  load_ev_t         ev_w;

  logic [CNT_W-1:0] ch_cmp [NUM_CH];
  logic [NUM_CH-1:0] ch_inv;
  logic [NUM_CH-1:0] ch_pwm;
  logic [NUM_CH-1:0] ch_evt;

  dsp_top_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk             (clk),
    .rst             (rst),
    .top_sel_i       (top_sel),
    .load_at_bottom_i(load_at_bottom),
    .cmp_a_wr_i      (cmp_a_wr),
    .cmp_a_wdata_i   (cmp_a_wdata),
    .period_wr_i     (period_wr),
    .period_wdata_i  (period_wdata),
    .ev_i            (ev_w),
    .top_o           (top_w),
    .cmp_a_o         (cmp_a_live)
  );

  dsp_updown_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .top_i (top_w),
    .cnt_o (count),
    .nxt_o (cnt_nxt),
    .down_o(count_down),
    .ev_o  (ev_w),
    .ovf_o (ovf_evt)
  );

  assign ch_cmp[0] = cmp_a_live;
  assign ch_cmp[1] = cmp_b;
  assign ch_inv    = {inv_b, inv_a};

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    dsp_cmp_chan #(.CNT_W(CNT_W)) u_chan (
      .clk   (clk),
      .rst   (rst),
      .tick  (tick),
      .cnt_i (count),
      .nxt_i (cnt_nxt),
      .down_i(count_down),
      .top_i (top_w),
      .cmp_i (ch_cmp[g]),
      .inv_i (ch_inv[g]),
      .pwm_o (ch_pwm[g]),
      .evt_o (ch_evt[g])
    );
  end

  assign pwm_a    = ch_pwm[0];
  assign pwm_b    = ch_pwm[1];
  assign cmpa_evt = ch_evt[0];
  assign cmpb_evt = ch_evt[1];

endmodule

// File: tb/dsp_pwm_timer_test.sv
module dsp_pwm_timer_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [2:0]  top_sel = 3'd0;
  logic        load_at_bottom = 1'b0;
  logic        inv_a = 1'b0;
  logic        inv_b = 1'b0;
  logic        cmp_a_wr = 1'b0;
  logic [15:0] cmp_a_wdata = 16'd0;
  logic        period_wr = 1'b0;
  logic [15:0] period_wdata = 16'd0;
  logic [15:0] cmp_b = 16'd0;
  logic [15:0] count;
  logic        count_down, pwm_a, pwm_b, ovf_evt, cmpa_evt, cmpb_evt;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;  // 250 MHz

  dsp_pwm_timer uut (
    .clk(clk), .rst(rst), .tick(tick), .top_sel(top_sel),
    .load_at_bottom(load_at_bottom), .inv_a(inv_a), .inv_b(inv_b),
    .cmp_a_wr(cmp_a_wr), .cmp_a_wdata(cmp_a_wdata),
    .period_wr(period_wr), .period_wdata(period_wdata), .cmp_b(cmp_b),
    .count(count), .count_down(count_down), .pwm_a(pwm_a), .pwm_b(pwm_b),
    .ovf_evt(ovf_evt), .cmpa_evt(cmpa_evt), .cmpb_evt(cmpb_evt)
  );

  typedef struct packed {
    logic [2:0]  sel;
    logic        ia;
    logic        ib;
    logic [15:0] ca;
    logic [15:0] cb;
    logic [15:0] per;
    logic [15:0] top;
    logic [15:0] ha;   // expected high clocks of pwm_a per cycle
    logic [15:0] hb;   // expected high clocks of pwm_b per cycle
  } vec_t;

  // R2 R5 R6 R7 vectors: ceiling source, modes, thresholds, expected duty
  localparam vec_t VECS [0:6] = '{
    '{3'd0, 1'b0, 1'b0, 16'd100,  16'd200, 16'd0,  16'd255,  16'd200,  16'd400},
    '{3'd1, 1'b1, 1'b0, 16'd11,   16'd0,   16'd0,  16'd511,  16'd1000, 16'd0},
    '{3'd2, 1'b0, 1'b1, 16'd1023, 16'd512, 16'd0,  16'd1023, 16'd2046, 16'd1022},
    '{3'd3, 1'b0, 1'b0, 16'd300,  16'd75,  16'd0,  16'd300,  16'd600,  16'd150},
    '{3'd4, 1'b1, 1'b0, 16'd0,    16'd40,  16'd40, 16'd40,   16'd80,   16'd80},
    '{3'd5, 1'b0, 1'b0, 16'd1,    16'd254, 16'd0,  16'd255,  16'd2,    16'd508},
    '{3'd0, 1'b1, 1'b1, 16'd255,  16'd1,   16'd0,  16'd255,  16'd0,    16'd508}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_evts(input int c, input int t);
    if (c == 0 || c == t) return 1;
    if (c > t) return 0;
    return 2;
  endfunction

  // Reset with the given configuration, then write the registers with tick low
  task automatic start(input logic [2:0] sel, input logic lab, input logic ia, input logic ib,
                       input logic [15:0] ca, input logic [15:0] cb, input logic [15:0] per);
    @(negedge clk);
    rst = 1'b1; tick = 1'b0; top_sel = sel; load_at_bottom = lab;
    inv_a = ia; inv_b = ib; cmp_b = cb;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    cmp_a_wr = 1'b1; cmp_a_wdata = ca;
    period_wr = 1'b1; period_wdata = per;
    @(negedge clk);
    cmp_a_wr = 1'b0; period_wr = 1'b0;
    tick = 1'b1;
  endtask

  task automatic wait_ovf();
    @(negedge clk);
    while (!ovf_evt) @(negedge clk);
  endtask

  // Start at an ovf clock; count over one 2*T cycle
  task automatic window(input int t, output int ha, output int hb, output int ea,
                        output int eb, output int mx);
    ha = 0; hb = 0; ea = 0; eb = 0; mx = 0;
    for (int i = 0; i < 2 * t; i++) begin
      ha += int'(pwm_a); hb += int'(pwm_b);
      ea += int'(cmpa_evt); eb += int'(cmpb_evt);
      if (int'(count) > mx) mx = int'(count);
      @(negedge clk);
    end
  endtask

  // Same window, writing a new channel-A value when the rising count hits 50
  task automatic window_wr(input int t, input logic [15:0] nv, output int ha);
    ha = 0;
    for (int i = 0; i < 2 * t; i++) begin
      ha += int'(pwm_a);
      cmp_a_wr = (count == 16'd50) && !count_down;
      cmp_a_wdata = nv;
      @(negedge clk);
    end
    cmp_a_wr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    int ha, hb, ea, eb, mx, n;

    // R12 reset state, inactive levels follow the mode inputs
    inv_a = 1'b1; inv_b = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 count", int'(count), 0);
    chk("R12 count_down", int'(count_down), 0);
    chk("R12 pwm_a", int'(pwm_a), 1);
    chk("R12 pwm_b", int'(pwm_b), 0);
    chk("R12 events", int'({ovf_evt, cmpa_evt, cmpb_evt}), 0);

    // Vector table walk: R1 period, R2 ceiling, R4 events, R5/R6/R7 duty
    foreach (VECS[k]) begin
      start(VECS[k].sel, 1'b0, VECS[k].ia, VECS[k].ib, VECS[k].ca, VECS[k].cb, VECS[k].per);
      wait_ovf(); wait_ovf();
      window(int'(VECS[k].top), ha, hb, ea, eb, mx);
      chk("R1 cycle ends with ovf_evt", int'(ovf_evt), 1);
      chk("R2 highest count", mx, int'(VECS[k].top));
      chk(VECS[k].ia ? "R6 pwm_a high clocks" : "R5 pwm_a high clocks", ha, int'(VECS[k].ha));
      chk(VECS[k].ib ? "R6 pwm_b high clocks" : "R7 pwm_b high clocks", hb, int'(VECS[k].hb));
      chk("R4 cmpa_evt pulses", ea, exp_evts(int'(VECS[k].ca), int'(VECS[k].top)));
      chk("R4 cmpb_evt pulses", eb, exp_evts(int'(VECS[k].cb), int'(VECS[k].top)));
    end

    // R3 direction around the ceiling and the bottom
    start(3'd0, 1'b0, 1'b0, 1'b0, 16'd10, 16'd20, 16'd0);
    while (count != 16'd255) @(negedge clk);
    chk("R3 count_down at ceiling", int'(count_down), 0);
    @(negedge clk);
    chk("R3 count after ceiling", int'(count), 254);
    chk("R3 count_down after ceiling", int'(count_down), 1);
    while (count != 16'd0) @(negedge clk);
    chk("R3 count_down at bottom", int'(count_down), 0);
    chk("R4 ovf_evt at bottom", int'(ovf_evt), 1);
    @(negedge clk);
    chk("R4 ovf_evt one clock", int'(ovf_evt), 0);

    // R1 tick low freezes count and outputs
    tick = 1'b0;
    @(negedge clk);
    n = int'(count);
    ha = int'(pwm_a);
    repeat (5) @(negedge clk);
    chk("R1 count held", int'(count), n);
    chk("R1 pwm_a held", int'(pwm_a), ha);
    tick = 1'b1;

    // R8 load at the ceiling: rising half 100, falling half 40
    start(3'd0, 1'b0, 1'b0, 1'b0, 16'd100, 16'd0, 16'd0);
    wait_ovf(); wait_ovf();
    window_wr(255, 16'd40, ha);
    chk("R8 mixed cycle high clocks", ha, 140);
    window(255, ha, hb, ea, eb, mx);
    chk("R8 next cycle high clocks", ha, 80);

    // R9 load at zero: whole cycle keeps 100, next uses 40
    start(3'd0, 1'b1, 1'b0, 1'b0, 16'd100, 16'd0, 16'd0);
    wait_ovf(); wait_ovf();
    window_wr(255, 16'd40, ha);
    chk("R9 symmetric cycle high clocks", ha, 200);
    window(255, ha, hb, ea, eb, mx);
    chk("R9 next cycle high clocks", ha, 80);

    // R11 ceiling 0 (live channel-A value still 0)
    start(3'd3, 1'b0, 1'b1, 1'b0, 16'd0, 16'd5, 16'd0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R11 count", int'(count), 0);
      chk("R11 ovf_evt", int'(ovf_evt), 1);
      chk("R11 outputs inactive", int'({pwm_a, pwm_b, count_down}), 3'b100);
    end

    // R10 period lowered below a rising count
    start(3'd4, 1'b0, 1'b0, 1'b0, 16'd0, 16'd0, 16'd1000);
    while (!(count == 16'd600 && !count_down)) @(negedge clk);
    period_wr = 1'b1; period_wdata = 16'd300;
    @(negedge clk);
    period_wr = 1'b0;
    while (count != 16'hFFFF) @(negedge clk);
    chk("R10 rising at 65535", int'(count_down), 0);
    @(negedge clk);
    chk("R10 wrap count", int'(count), 0);
    chk("R10 wrap ovf_evt", int'(ovf_evt), 1);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!ovf_evt);
    chk("R10 cycle after wrap", n, 600);

    disable watchdog;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule